// File: doc/BRIEF.md
# Halted-Core Idle and Interrupt-Acceptance Sequencer

This block models what an 8-bit CPU core does between executing HALT and accepting a maskable interrupt. A one-cycle pulse on `halt_exec` puts the block into the halted state. It then runs idle machine cycles until an interrupt is accepted. On acceptance it raises a single-cycle acknowledge, drops the halt indicator, asks the enable flip-flop to clear, and reports how many clocks passed between sampling the request and acknowledging it.

A build-time parameter `MODE` picks one of two behaviours. In the standard mode the halted core repeats four-clock idle machine cycles, each with a fetch strobe and a refresh strobe. The refresh register advances once per idle cycle. A request is honoured only when the enable flip-flop is set, and only at the end of the current idle cycle, so the wait varies with the cycle phase. In the alternate mode there are no idle cycles and no refresh, and the refresh register is frozen. Any request is taken at the edge that samples it, even with the enable flip-flop clear, and the flip-flop is then cleared again.

No data flows through this block, so it has no valid/ready pairs. Every pin is a plain control or status signal, and no input is ever stalled.

Top module: `halt_irq_seq`

## Requirements
- R1: A `halt_exec` pulse seen at a rising edge while not halted sets `halted` after that edge, and the idle cycle phase starts at 0. A `halt_exec` pulse while already halted does not restart the phase.
- R2: In standard mode, idle machine cycles last 4 clocks while halted. `m1_strobe` is high in the first clock (phase 0) and `rfsh_strobe` is high in the third clock (phase 2) of each one.
- R3: In standard mode, bits 6:0 of `refresh_reg` increase by one at the edge that ends each idle cycle and wrap from 127 to 0. Bit 7 is never changed.
- R4: In alternate mode, `m1_strobe` and `rfsh_strobe` stay low and `refresh_reg` holds its value for the whole halt.
- R5: In standard mode, the active-low request `int_n` is sampled at rising edges. When it is low with `iff_in` high at an edge in phase p, the acknowledge fires at the edge that ends that idle cycle. This gives a latency of 3 - p clocks, between 0 and 3.
- R6: In standard mode, a low `int_n` with `iff_in` low is ignored. The block stays halted and never acknowledges.
- R7: In alternate mode, a low `int_n` sampled while halted is accepted at that same edge, whatever `iff_in` is, with a reported latency of 0.
- R8: An acceptance raises `ack_strobe` and `iff_clear` for exactly one clock, starting right after the accepting edge. In that same clock `halted` is low and `ack_latency` shows the measured latency, which it keeps until the next acceptance.
- R9: Reset (`rst_n` low) clears `halted`, `refresh_reg`, `ack_strobe`, `iff_clear`, `ack_latency` and both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_exec | input | 1 | One-cycle pulse: HALT was executed |
| int_n | input | 1 | Maskable interrupt request, active low |
| iff_in | input | 1 | Current state of the interrupt-enable flip-flop |
| halted | output | 1 | Core is halted |
| m1_strobe | output | 1 | Idle fetch cycle marker (standard mode) |
| rfsh_strobe | output | 1 | Refresh cycle marker (standard mode) |
| refresh_reg | output | 8 | Refresh register |
| ack_strobe | output | 1 | Interrupt acknowledge, one clock |
| iff_clear | output | 1 | Request to clear the enable flip-flop, one clock |
| ack_latency | output | 2 | Clocks from request sample to acknowledge |

## Verification
The request is driven on a falling edge and sampled at the next rising edge. The alternate instance must therefore show `ack_strobe`, `iff_clear`, low `halted` and zero latency at the very next falling edge. The standard instance must show them exactly 3 - p falling edges later. The bench records the falling edge at which each acknowledge first appears and compares it with that count, and also checks the reported latency and the refresh value in that same clock. The strobes and the refresh value are checked at each falling edge from halt entry onward, with idle cycle k covering edges 4k to 4k+3.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;
  typedef enum logic {
    MODE_STD = 1'b0,
    MODE_VAR = 1'b1
  } halt_mode_e;

  localparam int REFRESH_W = 8;
endpackage

// File: rtl/halt_phase_ctr.sv
module halt_phase_ctr #(
  parameter int NOP_CYCLES = 4,
  localparam int PH_W = $clog2(NOP_CYCLES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_exec,
  input  logic            leave,
  output logic            halted,
  output logic [PH_W-1:0] phase,
  output logic            nop_last
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NOP_CYCLES - 1);

  assign nop_last = halted && (phase == LAST_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted <= 1'b0;
      phase  <= '0;
    end else if (!halted) begin
      if (halt_exec) begin
        halted <= 1'b1;
        phase  <= '0;
      end
    end else if (leave) begin
      halted <= 1'b0;
      phase  <= '0;
    end else begin
      phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
    end
  end

  p_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && halt_exec) |=> (halted && phase == '0));

  p_no_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !leave && halt_exec && !nop_last) |=> (phase != '0));
endmodule

// File: rtl/halt_refresh_ctr.sv
module halt_refresh_ctr
  import halt_seq_pkg::*;
#(
  parameter halt_mode_e MODE = MODE_STD
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 nop_last,
  output logic [REFRESH_W-1:0] refresh_q
);
  generate
    if (MODE == MODE_STD) begin : g_std
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          refresh_q <= '0;
        end else if (nop_last) begin
          refresh_q[REFRESH_W-2:0] <= refresh_q[REFRESH_W-2:0] + 1'b1;
        end
      end
    end else begin : g_var
      logic unused_last;
      assign unused_last = nop_last;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) refresh_q <= '0;
        else        refresh_q <= refresh_q;
      end
    end
  endgenerate

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == MODE_STD && nop_last) |=>
      (refresh_q[REFRESH_W-2:0] == REFRESH_W'($past(refresh_q[REFRESH_W-2:0]) + 1'b1) % (2**(REFRESH_W-1))
       && refresh_q[REFRESH_W-1] == $past(refresh_q[REFRESH_W-1])));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == MODE_VAR) |=> $stable(refresh_q));
endmodule

// File: rtl/halt_irq_accept.sv
module halt_irq_accept
  import halt_seq_pkg::*;
#(
  parameter halt_mode_e MODE = MODE_STD,
  parameter int LAT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_n,
  input  logic             iff_in,
  input  logic             halted,
  input  logic             nop_last,
  output logic             leave,
  output logic             ack_q,
  output logic [LAT_W-1:0] lat_q
);
  logic             pend;
  logic [LAT_W-1:0] lat_cnt;
  logic             take_now;
  logic [LAT_W-1:0] lat_now;

  generate
    if (MODE == MODE_STD) begin : g_std
      assign take_now = halted && !int_n && iff_in && !pend;
      assign leave    = nop_last && (pend || take_now);
      assign lat_now  = pend ? lat_cnt + 1'b1 : '0;
    end else begin : g_var
      logic unused_sig;
      assign unused_sig = iff_in ^ nop_last ^ (|lat_cnt);
      assign take_now   = 1'b0;
      assign leave      = halted && !int_n;
      assign lat_now    = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      lat_cnt <= '0;
      ack_q   <= 1'b0;
      lat_q   <= '0;
    end else begin
      ack_q <= leave;
      if (leave) begin
        pend  <= 1'b0;
        lat_q <= lat_now;
      end else if (take_now) begin
        pend <= 1'b1;
      end
      if (take_now)  lat_cnt <= '0;
      else if (pend) lat_cnt <= lat_cnt + 1'b1;
    end
  end

  p_ack_at_nop_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == MODE_STD && ack_q) |-> $past(nop_last));

  p_ignore_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == MODE_STD && halted && !pend && !iff_in) |=> !ack_q);

  p_zero_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == MODE_VAR && halted && !int_n) |=> (ack_q && lat_q == '0));
endmodule

// File: rtl/halt_irq_seq.sv
module halt_irq_seq
  import halt_seq_pkg::*;
#(
  parameter halt_mode_e MODE = MODE_STD,
  parameter int NOP_CYCLES = 4,
  localparam int LAT_W = $clog2(NOP_CYCLES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 halt_exec,
  input  logic                 int_n,
  input  logic                 iff_in,
  output logic                 halted,
  output logic                 m1_strobe,
  output logic                 rfsh_strobe,
  output logic [REFRESH_W-1:0] refresh_reg,
  output logic                 ack_strobe,
  output logic                 iff_clear,
  output logic [LAT_W-1:0]     ack_latency
);
  localparam logic [LAT_W-1:0] RFSH_PH = LAT_W'(NOP_CYCLES / 2);

  logic             halted_w;
  logic [LAT_W-1:0] phase_w;
  logic             nop_last_w;
  logic             leave_w;
  logic             ack_w;

  halt_phase_ctr #(.NOP_CYCLES(NOP_CYCLES)) u_phase (
    .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec), .leave(leave_w),
    .halted(halted_w), .phase(phase_w), .nop_last(nop_last_w)
  );

  halt_refresh_ctr #(.MODE(MODE)) u_refresh (
    .clk(clk), .rst_n(rst_n), .nop_last(nop_last_w), .refresh_q(refresh_reg)
  );

  halt_irq_accept #(.MODE(MODE), .LAT_W(LAT_W)) u_accept (
    .clk(clk), .rst_n(rst_n), .int_n(int_n), .iff_in(iff_in),
    .halted(halted_w), .nop_last(nop_last_w), .leave(leave_w),
    .ack_q(ack_w), .lat_q(ack_latency)
  );

  generate
    if (MODE == MODE_STD) begin : g_strobe_std
      assign m1_strobe   = halted_w && (phase_w == '0);
      assign rfsh_strobe = halted_w && (phase_w == RFSH_PH);
    end else begin : g_strobe_var
      assign m1_strobe   = 1'b0;
      assign rfsh_strobe = 1'b0;
    end
  endgenerate

  assign halted     = halted_w;
  assign ack_strobe = ack_w;
  assign iff_clear  = ack_w;

  p_ack_exits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strobe |-> (!halted && iff_clear));

  p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strobe |=> !ack_strobe);

  p_strobes_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> !(m1_strobe || rfsh_strobe));

  p_no_strobes_var_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == MODE_VAR) |-> $onehot0({m1_strobe, rfsh_strobe}) && !m1_strobe && !rfsh_strobe);
endmodule

// File: tb/halt_irq_seq_bench.sv
module halt_irq_seq_bench;
  import halt_seq_pkg::*;

  localparam int CLK_PERIOD = 10;

  // row: {iff[15], delay[14:11], std_acks[10], std_lat[9:8], std_refresh[7:0]}
  localparam int NROWS = 6;
  localparam logic [15:0] VEC [NROWS] = '{
    {1'b1, 4'd0, 1'b1, 2'd3, 8'd1},
    {1'b1, 4'd1, 1'b1, 2'd2, 8'd1},
    {1'b1, 4'd2, 1'b1, 2'd1, 8'd1},
    {1'b1, 4'd3, 1'b1, 2'd0, 8'd1},
    {1'b1, 4'd5, 1'b1, 2'd2, 8'd2},
    {1'b0, 4'd1, 1'b0, 2'd0, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_exec = 1'b0;
  logic int_n = 1'b1;
  logic iff_in = 1'b0;

  logic       s_halted, s_m1, s_rfsh, s_ack, s_clr;
  logic [7:0] s_r;
  logic [1:0] s_lat;
  logic       v_halted, v_m1, v_rfsh, v_ack, v_clr;
  logic [7:0] v_r;
  logic [1:0] v_lat;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_irq_seq #(.MODE(MODE_STD)) u_halt_irq_seq (
    .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec), .int_n(int_n), .iff_in(iff_in),
    .halted(s_halted), .m1_strobe(s_m1), .rfsh_strobe(s_rfsh), .refresh_reg(s_r),
    .ack_strobe(s_ack), .iff_clear(s_clr), .ack_latency(s_lat)
  );

  halt_irq_seq #(.MODE(MODE_VAR)) u_halt_irq_seq_var (
    .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec), .int_n(int_n), .iff_in(iff_in),
    .halted(v_halted), .m1_strobe(v_m1), .rfsh_strobe(v_rfsh), .refresh_reg(v_r),
    .ack_strobe(v_ack), .iff_clear(v_clr), .ack_latency(v_lat)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; halt_exec = 1'b0; int_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9: everything cleared while reset is held
    chk("R9", "std halted", s_halted, 0);
    chk("R9", "std refresh", s_r, 0);
    chk("R9", "std ack/clr/lat/strobes", {s_ack, s_clr, s_lat, s_m1, s_rfsh}, 0);
    chk("R9", "var halted/ack/refresh", {v_halted, v_ack, v_clr, v_r}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic enter_halt();
    @(negedge clk) halt_exec = 1'b1;
    @(negedge clk) halt_exec = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // table walk: R5, R7, R8
    for (int i = 0; i < NROWS; i++) begin
      int s_c, v_c;
      logic [15:0] row;
      row = VEC[i];
      do_reset();
      iff_in = row[15];
      enter_halt();
      chk("R1", "std halted after entry", s_halted, 1);
      repeat (int'(row[14:11])) @(negedge clk);
      int_n = 1'b0;
      s_c = -1; v_c = -1;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (s_ack && s_c < 0) begin
          s_c = c;
          chk("R5", "std latency report", s_lat, int'(row[9:8]));
          chk("R8", "std halted/clr with ack", {s_halted, s_clr}, 2'b01);
          chk("R3", "std refresh at ack", s_r, int'(row[7:0]));
        end
        if (v_ack && v_c < 0) begin
          v_c = c;
          chk("R7", "var latency report", v_lat, 0);
          chk("R8", "var halted/clr with ack", {v_halted, v_clr}, 2'b01);
          chk("R4", "var refresh frozen", v_r, 0);
        end
        if (c == v_c + 1 && v_c >= 0) chk("R8", "var ack one clock", v_ack, 0);
      end
      int_n = 1'b1;
      chk(row[10] ? "R5" : "R6", "std ack edge", s_c, row[10] ? int'(row[9:8]) : -1);
      chk("R7", "var ack edge", v_c, 0);
    end

    // R2, R3, R4: strobe pattern and refresh counting over two idle cycles
    do_reset();
    iff_in = 1'b0;
    enter_halt();
    for (int k = 0; k < 9; k++) begin
      chk("R2", "std m1", s_m1, (k % 4 == 0) ? 1 : 0);
      chk("R2", "std rfsh", s_rfsh, (k % 4 == 2) ? 1 : 0);
      chk("R3", "std refresh count", s_r, k / 4);
      chk("R4", "var strobes/refresh", {v_m1, v_rfsh, v_r}, 0);
      @(negedge clk);
    end

    // R1: a second HALT while halted does not restart the idle cycle
    do_reset();
    enter_halt();
    @(negedge clk);
    @(negedge clk) halt_exec = 1'b1;
    @(negedge clk) halt_exec = 1'b0;
    chk("R1", "no m1 after repeat HALT", s_m1, 0);
    @(negedge clk);
    chk("R1", "m1 at original cycle start", s_m1, 1);

    // R6 + R3 wrap: masked request over 129 idle cycles
    do_reset();
    iff_in = 1'b0;
    enter_halt();
    int_n = 1'b0;
    begin
      int s_acks;
      s_acks = 0;
      for (int k = 1; k <= 516; k++) begin
        @(negedge clk);
        if (s_ack || !s_halted) s_acks++;
      end
      chk("R6", "std never acks when masked", s_acks, 0);
      chk("R6", "std still halted", s_halted, 1);
      chk("R3", "refresh wraps 127->0, bit7 kept", s_r, 1);
      chk("R7", "var left halt despite mask", v_halted, 0);
    end
    int_n = 1'b1;

    // R9: reset in the middle of a halt
    do_reset();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule